// File: doc/BRIEF.md
# Interleaved Three-Converter Start Scheduler

This block staggers start-of-conversion pulses across three converter channels so that their samples fall at evenly spaced points in time. One external trigger starts a round: converter 1 starts first, then converter 2, then converter 3, each start separated by a fixed spacing. The block takes a 4-bit delay setting and a sampling time. The spacing is the delay setting plus five clocks, but it never drops below the sampling time plus two clocks, so a new converter is never started while the previous one is still sampling.

In single-shot operation one trigger gives one round of three starts. In continuous operation the rotation wraps back to converter 1 and keeps running with no further trigger. A 5-bit mode input enables the scheduler only when it holds the interleaved code; any other code parks it. An interruption input stops a running round and locks the scheduler. The lock is released only when the mode input passes through the all-zero independent code. A simple timing model for each converter raises a one-clock completion pulse a fixed number of clocks after its start.

Top module: `interleave_sched`

## Requirements
- R1: Starts go to the converters in the order converter 1 (`start_o[0]`), converter 2 (`start_o[1]`), converter 3 (`start_o[2]`), then back to converter 1. Every round begins at converter 1.
- R2: The spacing between successive starts is max(delay_i + 5, smp_i + 2) clocks. Both values are captured when the trigger is accepted, and later changes to them do not affect the running round.
- R3: Each start pulse is exactly one clock wide, and at most one bit of `start_o` is high in any cycle.
- R4: With `cont_i` low, one accepted trigger produces exactly three starts, and then the scheduler returns to idle.
- R5: With `cont_i` high, converter 1 is started again one spacing after converter 3, and the rotation continues with no new trigger.
- R6: A trigger that arrives while a round is running is ignored and does not change the timing or the order of the starts.
- R7: While `mode_i` differs from the interleaved code 5'b10111, no start is issued and any running round stops. The next accepted trigger then starts at converter 1.
- R8: A high `abort_i` stops the round and locks the scheduler. While locked, triggers are ignored, even in interleaved mode. The lock clears only when `mode_i` equals 5'b00000.
- R9: `done_o[i]` is a one-clock pulse that rises smp_i + 12 clocks after `start_o[i]` rises, using the smp_i value seen at that start.
- R10: The first start of a round appears in the cycle right after the clock edge that samples an accepted trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 5 | Mode code: 5'b10111 interleaved, 5'b00000 independent (clears the lock) |
| cont_i | input | 1 | High selects continuous rotation |
| delay_i | input | 4 | Spacing setting; the spacing is this value plus 5 clocks |
| smp_i | input | 5 | Sampling time in clocks |
| trig_i | input | 1 | External trigger that starts a round |
| abort_i | input | 1 | Interrupts the round and locks the scheduler |
| start_o | output | 3 | One-clock start pulses, bit i for converter i+1 |
| done_o | output | 3 | One-clock conversion-complete pulses from the timing model |

## Verification
The bench runs the two clamp regimes of the spacing: one where the delay setting decides, one where the sampling time decides, and the floor where both are zero. A design that used only the delay setting would start converters 10 clocks apart instead of 17 when the sampling time is 15. A design that did not capture the settings would shorten the spacing in the middle of a round. The bench also sends triggers in the middle of a round, leaves interleaved mode in the middle of a round, and applies an abort. It checks that the abort holds the scheduler locked until the independent code has been seen, and that the next round starts at converter 1. A design that kept its pointer or ignored the lock would start the wrong converter, or would restart without the independent step. In continuous mode the bench follows the wrap from converter 3 back to converter 1.

// File: rtl/interleave_pkg.sv
// Package: shared constants and types for the interleaved start scheduler.
// Assumes three converters and a 5-bit mode field.
package interleave_pkg;
    localparam int MODE_W = 5;
    localparam logic [MODE_W-1:0] MODE_INDEP = 5'b00000;
    localparam logic [MODE_W-1:0] MODE_INTL3 = 5'b10111;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/interleave_spacing.sv
// Module: interleave_spacing
// Works out the start-to-start spacing: the larger of the delay setting
// plus its base offset and the sampling time plus its pad.
// Assumes SP_W is wide enough for both sums (the top derives it).
module interleave_spacing #(
    parameter int DLY_W    = 4,
    parameter int SMP_W    = 5,
    parameter int SP_W     = 7,
    parameter int DLY_BASE = 5,
    parameter int SMP_PAD  = 2
) (
    input  logic [DLY_W-1:0] delay_i,
    input  logic [SMP_W-1:0] smp_i,
    output logic [SP_W-1:0]  spacing_o
);
    logic [SP_W-1:0] dly_sum;
    logic [SP_W-1:0] smp_sum;

    // Both candidate spacings, then the larger of the two
    always_comb begin
        dly_sum   = SP_W'(delay_i) + SP_W'(DLY_BASE);
        smp_sum   = SP_W'(smp_i) + SP_W'(SMP_PAD);
        spacing_o = (dly_sum > smp_sum) ? dly_sum : smp_sum;
    end

    // The spacing honours both floors (R2)
    always_comb begin
        assert_spacing_floor_R2: assert (spacing_o >= smp_sum && spacing_o >= dly_sum);
    end
endmodule

// File: rtl/interleave_seq.sv
// Module: interleave_seq
// Round-robin sequencer. It accepts a trigger, issues one-hot start pulses
// one spacing apart, wraps or stops depending on cont_i, parks outside
// interleaved mode, and stays locked after an abort until the independent
// code is seen.
// Assumes spacing_i >= 2, so that pulses never merge.
module interleave_seq
    import interleave_pkg::*;
#(
    parameter int NCONV = 3,
    parameter int SP_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cont_i,
    input  logic              trig_i,
    input  logic              abort_i,
    input  logic [SP_W-1:0]   spacing_i,
    output logic [NCONV-1:0]  start_o
);
    localparam int PTR_W = (NCONV > 1) ? $clog2(NCONV) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NCONV - 1);
    localparam logic [NCONV-1:0] ONE_HOT0 = NCONV'(1);

    seq_state_e       st_q;
    logic [PTR_W-1:0] ptr_q;
    logic [SP_W-1:0]  cnt_q;
    logic [SP_W-1:0]  sp_q;
    logic [NCONV-1:0] start_q;
    logic             locked_q;
    logic             first_q;
    logic [SP_W-1:0]  gap_q;
    logic             intl;

    // Mode decode for the interleaved code
    always_comb intl = (mode_i == MODE_INTL3);

    // Abort lock: set by abort, cleared by the independent code
    always_ff @(posedge clk) begin
        if (!rst_n)                    locked_q <= 1'b0;
        else if (abort_i)              locked_q <= 1'b1;
        else if (mode_i == MODE_INDEP) locked_q <= 1'b0;
    end

    // Sequencer state, rotation pointer, spacing counter and start pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SEQ_IDLE;
            ptr_q   <= '0;
            cnt_q   <= '0;
            sp_q    <= '0;
            start_q <= '0;
            first_q <= 1'b0;
        end else begin
            start_q <= '0;
            first_q <= 1'b0;
            if (abort_i || !intl) begin
                st_q  <= SEQ_IDLE;
                ptr_q <= '0;
                cnt_q <= '0;
            end else begin
                case (st_q)
                    SEQ_IDLE: begin
                        if (trig_i && !locked_q) begin
                            st_q    <= SEQ_RUN;
                            start_q <= ONE_HOT0;
                            first_q <= 1'b1;
                            ptr_q   <= PTR_W'(1);
                            sp_q    <= spacing_i;
                            cnt_q   <= spacing_i - SP_W'(1);
                        end
                    end
                    SEQ_RUN: begin
                        if (cnt_q == '0) begin
                            start_q <= ONE_HOT0 << ptr_q;
                            cnt_q   <= sp_q - SP_W'(1);
                            if (ptr_q == PTR_LAST) begin
                                ptr_q <= '0;
                                if (!cont_i) st_q <= SEQ_IDLE;
                            end else begin
                                ptr_q <= ptr_q + PTR_W'(1);
                            end
                        end else begin
                            cnt_q <= cnt_q - SP_W'(1);
                        end
                    end
                    default: st_q <= SEQ_IDLE;
                endcase
            end
        end
    end

    // Independent cycle counter since the last start, used by the checks
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_q <= '0;
        else if (start_q != '0)  gap_q <= SP_W'(1);
        else if (gap_q != '1)    gap_q <= gap_q + SP_W'(1);
    end

    assign start_o = start_q;

    // R3: at most one converter is started in any cycle
    assert_onehot_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_q));

    // R3: a start pulse lasts one clock
    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q != '0) |=> (start_q == '0));

    // R2: every start after the first of a round is one captured spacing later
    assert_spacing_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q != '0 && !first_q) |-> (gap_q == sp_q));

    // R7: no start while the mode is not interleaved
    assert_park_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !intl |=> (start_q == '0));

    // R8: no start while locked
    assert_lock_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> (start_q == '0));
endmodule

// File: rtl/interleave_conv_model.sv
// Module: interleave_conv_model
// Timing model of one converter. A start pulse captures the sampling time.
// The done pulse rises smp + CONV_LAT clocks after the start rises.
// A new start during a conversion restarts the count.
// Assumes CONV_LAT >= 2.
module interleave_conv_model #(
    parameter int SMP_W    = 5,
    parameter int CONV_LAT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SMP_W-1:0] smp_i,
    output logic             done_o
);
    localparam int CW = $clog2((1 << SMP_W) + CONV_LAT) + 1;

    logic [CW-1:0] total;
    logic [CW-1:0] cnt_q;
    logic          act_q;
    logic          done_q;

    // Full duration of the conversion from the current sampling time
    always_comb total = CW'(smp_i) + CW'(CONV_LAT);

    // Countdown from start to completion, with a one-clock done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            act_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                cnt_q <= total - CW'(2);
                act_q <= 1'b1;
            end else if (act_q) begin
                if (cnt_q == '0) begin
                    done_q <= 1'b1;
                    act_q  <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end

    assign done_o = done_q;

    // R9: the done pulse is one clock wide
    assert_done_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: done only follows an active conversion
    assert_done_after_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(act_q));
endmodule

// File: rtl/interleave_sched.sv
// Module: interleave_sched (top)
// Interleaved start scheduler for NCONV converters. It ties the spacing
// calculator, the round-robin sequencer and one timing model per converter.
// Assumes synchronous inputs and DLY_BASE >= 2.
module interleave_sched
    import interleave_pkg::*;
#(
    parameter int NCONV    = 3,
    parameter int DLY_W    = 4,
    parameter int SMP_W    = 5,
    parameter int DLY_BASE = 5,
    parameter int SMP_PAD  = 2,
    parameter int CONV_LAT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cont_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic [SMP_W-1:0]  smp_i,
    input  logic              trig_i,
    input  logic              abort_i,
    output logic [NCONV-1:0]  start_o,
    output logic [NCONV-1:0]  done_o
);
    localparam int SP_W = ((SMP_W > DLY_W) ? SMP_W : DLY_W) + 2;

    logic [SP_W-1:0]  spacing;
    logic [NCONV-1:0] start_w;

    // Spacing from the delay setting and the sampling time
    interleave_spacing #(
        .DLY_W(DLY_W), .SMP_W(SMP_W), .SP_W(SP_W),
        .DLY_BASE(DLY_BASE), .SMP_PAD(SMP_PAD)
    ) u_spacing (
        .delay_i  (delay_i),
        .smp_i    (smp_i),
        .spacing_o(spacing)
    );

    // Round-robin start sequencer
    interleave_seq #(.NCONV(NCONV), .SP_W(SP_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_i),
        .cont_i   (cont_i),
        .trig_i   (trig_i),
        .abort_i  (abort_i),
        .spacing_i(spacing),
        .start_o  (start_w)
    );

    // One conversion timing model for each converter
    for (genvar g = 0; g < NCONV; g++) begin : g_conv
        interleave_conv_model #(.SMP_W(SMP_W), .CONV_LAT(CONV_LAT)) u_conv (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(start_w[g]),
            .smp_i  (smp_i),
            .done_o (done_o[g])
        );
    end

    assign start_o = start_w;
endmodule

// File: tb/tb_interleave_sched.sv
// Directed bench for interleave_sched. Inputs change and outputs are
// sampled at the falling edge. The start and done pulses are logged
// with a cycle index.
module tb_interleave_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] mode_i = 5'b10111;
    logic       cont_i = 1'b0;
    logic [3:0] delay_i = 4'd0;
    logic [4:0] smp_i = 5'd0;
    logic       trig_i = 1'b0;
    logic       abort_i = 1'b0;
    logic [2:0] start_o;
    logic [2:0] done_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int st_cyc [64];
    int st_val [64];
    int st_n = 0;
    int dn_cyc [64];
    int dn_val [64];
    int dn_n = 0;

    localparam logic [4:0] INTL = 5'b10111;

    interleave_sched dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cont_i(cont_i),
        .delay_i(delay_i), .smp_i(smp_i), .trig_i(trig_i), .abort_i(abort_i),
        .start_o(start_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (start_o != 3'b000 && st_n < 64) begin
            st_cyc[st_n] = cyc; st_val[st_n] = int'(start_o); st_n++;
        end
        if (done_o != 3'b000 && dn_n < 64) begin
            dn_cyc[dn_n] = cyc; dn_val[dn_n] = int'(done_o); dn_n++;
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_log();
        st_n = 0;
        dn_n = 0;
    endtask

    task automatic pulse_trig(output int t0);
        trig_i = 1'b1;
        t0 = cyc;
        step();
        trig_i = 1'b0;
    endtask

    task automatic check_starts(input string req, input int t0, input int sp, input int n);
        chk({req, " start count"}, st_n, n);
        for (int i = 0; i < n && i < st_n; i++) begin
            chk({req, " start time"}, st_cyc[i], t0 + 1 + i * sp);
            chk({req, " start order"}, st_val[i], 1 << (i % 3));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        steps(3);
        chk("R3 reset start_o", int'(start_o), 0);
        chk("R9 reset done_o", int'(done_o), 0);
        rst_n = 1'b1;
        steps(2);
    endtask

    task automatic t_single_smp_clamp();
        int t0;
        mode_i = INTL; cont_i = 1'b0; delay_i = 4'd5; smp_i = 5'd15;
        clear_log();
        pulse_trig(t0);
        steps(80);
        // R1 R2 R4 R10: spacing 17 from the sampling-time floor
        check_starts("R2", t0, 17, 3);
        chk("R4 three starts only", st_n, 3);
        chk("R9 done count", dn_n, 3);
        for (int i = 0; i < 3 && i < dn_n; i++) begin
            chk("R9 done time", dn_cyc[i], t0 + 1 + i * 17 + 27);
            chk("R9 done converter", dn_val[i], 1 << i);
        end
    endtask

    task automatic t_delay_wins_latched();
        int t0;
        delay_i = 4'd15; smp_i = 5'd3;
        clear_log();
        pulse_trig(t0);
        delay_i = 4'd0;
        steps(60);
        // R2: spacing 20 set by the delay setting, captured at trigger
        check_starts("R2 latched", t0, 20, 3);
    endtask

    task automatic t_min_floor();
        int t0;
        delay_i = 4'd0; smp_i = 5'd0;
        clear_log();
        pulse_trig(t0);
        steps(25);
        // R10 R1: floor spacing of 5
        check_starts("R10", t0, 5, 3);
    endtask

    task automatic t_ignored_trig();
        int t0;
        delay_i = 4'd3; smp_i = 5'd1;
        clear_log();
        pulse_trig(t0);
        steps(3);
        trig_i = 1'b1; step(); trig_i = 1'b0;
        steps(5);
        trig_i = 1'b1; step(); trig_i = 1'b0;
        steps(30);
        // R6: spacing 8, triggers in mid-round change nothing
        check_starts("R6", t0, 8, 3);
    endtask

    task automatic t_continuous();
        int t0;
        cont_i = 1'b1; delay_i = 4'd2; smp_i = 5'd4;
        clear_log();
        pulse_trig(t0);
        steps(45);
        // R5: wraps with spacing 7 and no new trigger
        check_starts("R5", t0, 7, 7);
        mode_i = 5'b00000;
        steps(30);
        chk("R7 stop on mode change", st_n, 7);
        mode_i = INTL;
        cont_i = 1'b0;
        steps(2);
    endtask

    task automatic t_park();
        int t0;
        delay_i = 4'd0; smp_i = 5'd0;
        mode_i = 5'b00000;
        clear_log();
        pulse_trig(t0);
        steps(20);
        chk("R7 no start in independent", st_n, 0);
        mode_i = INTL;
        step();
        clear_log();
        pulse_trig(t0);
        steps(7);
        mode_i = 5'b00001;
        steps(3);
        mode_i = INTL;
        steps(15);
        chk("R7 stopped mid-round", st_n, 2);
        clear_log();
        pulse_trig(t0);
        steps(15);
        check_starts("R7 restart at converter 1", t0, 5, 3);
    endtask

    task automatic t_abort_lock();
        int t0;
        delay_i = 4'd0; smp_i = 5'd0;
        clear_log();
        pulse_trig(t0);
        steps(2);
        abort_i = 1'b1; step(); abort_i = 1'b0;
        steps(20);
        chk("R8 abort stops round", st_n, 1);
        clear_log();
        pulse_trig(t0);
        steps(20);
        chk("R8 locked ignores trigger", st_n, 0);
        mode_i = 5'b00000; step();
        mode_i = INTL; step();
        clear_log();
        pulse_trig(t0);
        steps(15);
        check_starts("R8 rearmed", t0, 5, 3);
    endtask

    initial begin
        t_reset();
        t_single_smp_clamp();
        t_delay_wins_latched();
        t_min_floor();
        t_ignored_trig();
        t_continuous();
        t_park();
        t_abort_lock();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule